// File: doc/BRIEF.md
# SPI NAND Command Frame Engine

This block runs one complete command exchange with a serial NAND flash over a single-lane SPI link. A host hands it a command descriptor: an opcode, up to three address bytes with a count, a number of dummy bytes, a data byte count and a read/write flag. The block lowers chip select and clocks out the opcode. It then sends the address bytes and the dummy bytes. Last comes a data phase in one direction only. Chip select is raised once the final byte is complete, and a completion pulse follows.

Write data comes in on a byte stream with valid/ready. Read data goes out on a second byte stream with valid/ready. If the write stream runs dry, the serial clock stops. If the read stream is not accepted, the serial clock also stops. The link runs in SPI mode 0 with the most significant bit first. The serial clock half-period is a whole number of system clock cycles, set by a parameter.

Top module: `snf_frame_engine`

## Requirements
- R1: A descriptor is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no frame is in progress. A `cmd_valid` pulse during a frame has no effect on that frame and does not start a new one.
- R2: Each frame begins with exactly one opcode byte. Next come `cmd_addr_cnt` address bytes (0 to 3). With N address bytes, the k-th address byte sent (k counting from 0) is `cmd_addr[8*(N-1-k) +: 8]`, so the lowest N bytes go out most significant first. A count of zero sends no address bytes.
- R3: After the address bytes, `cmd_dummy_cnt` dummy bytes are sent, each as 0xFF on `spi_mosi`. A count of zero skips this phase.
- R4: The data phase comes last and carries `cmd_data_cnt` bytes. When `cmd_read`=1, MOSI carries 0xFF and each byte received on MISO is delivered on `rx_data`. When `cmd_read`=0, the bytes taken from `tx_data` are sent. A count of zero ends the frame after the earlier phases.
- R5: Timing follows SPI mode 0 with the MSB first. `spi_sclk` idles low. MOSI changes only while SCLK is low. MISO is captured when SCLK rises.
- R6: `spi_cs_n` goes low after a descriptor is accepted and stays low, without a break, until the last byte has finished. `spi_sclk` is high only while `spi_cs_n` is low.
- R7: `done` is high for exactly one cycle. That cycle is the one right after the cycle in which `spi_cs_n` returns high.
- R8: In a write data phase, `tx_ready` is high while the block waits for the next byte. A byte is taken when `tx_valid` and `tx_ready` are both high. While `tx_valid` stays low, SCLK stays low.
- R9: `rx_valid` stays high and `rx_data` stays unchanged until `rx_ready` is high. The next read byte is not clocked until the current one has been accepted.
- R10: A data phase of 2112 bytes completes with every byte in place, using the default 12-bit count.
- R11: After reset, `spi_cs_n`=1, `spi_sclk`=0, `cmd_ready`=1, and `done`, `tx_ready` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Descriptor valid |
| cmd_ready | output | 1 | Engine idle, descriptor can be taken |
| cmd_opcode | input | 8 | Opcode byte |
| cmd_addr | input | ADDR_BYTES*8 | Address bytes, low N used |
| cmd_addr_cnt | input | AC_W | Number of address bytes |
| cmd_dummy_cnt | input | DUMMY_W | Number of 0xFF dummy bytes |
| cmd_data_cnt | input | CNT_W | Number of data bytes |
| cmd_read | input | 1 | 1 = receive data phase, 0 = transmit |
| tx_data | input | 8 | Write data byte |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Engine waiting for a write byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Consumer accepts received byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
A wrong phase pointer or a bad per-phase byte index shows up within one byte time, about 16 half-periods. It appears as a byte out of place or a wrong byte count on MOSI between the falling and rising edges of chip select. A fault in the bit shifter shows up as a corrupted MISO byte on `rx_data` at the next read. A stuck flow-control condition shows up as SCLK activity while `tx_valid` is low or while `rx_valid` waits unaccepted. A bad close sequence is visible within two cycles of the last falling edge of SCLK. It appears as a chip-select glitch, a missing `done`, or a `done` that lasts longer than one cycle.

// File: rtl/snf_pkg.sv
package snf_pkg;
   typedef enum logic [1:0] {
      PH_OPC   = 2'd0,
      PH_ADDR  = 2'd1,
      PH_DUMMY = 2'd2,
      PH_DATA  = 2'd3
   } snf_phase_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LAUNCH = 3'd1,
      ST_SHIFT  = 3'd2,
      ST_CLOSE  = 3'd3,
      ST_FIN    = 3'd4
   } snf_state_e;

   localparam logic [7:0] SNF_FILL = 8'hFF;
endpackage

// File: rtl/snf_byte_shifter.sv
module snf_byte_shifter #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       busy,
   output logic       last_edge,
   output logic [7:0] rx_byte
);
   logic       tick;
   logic       sclk_q;
   logic       busy_q;
   logic [2:0] bit_q;
   logic [7:0] sh_q;
   logic [7:0] rx_q;

   generate
      if (HALF_DIV == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         localparam int DIV_W = $clog2(HALF_DIV);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (go || !busy_q || div_q == DIV_W'(HALF_DIV - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = busy_q && (div_q == DIV_W'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         busy_q <= 1'b0;
         bit_q  <= '0;
         sh_q   <= 8'hFF;
         rx_q   <= '0;
      end else if (go) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         bit_q  <= '0;
         sh_q   <= tx_byte;
      end else if (tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso};
         end else begin
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
               busy_q <= 1'b0;
               sh_q   <= 8'hFF;
            end else begin
               bit_q <= bit_q + 1'b1;
               sh_q  <= {sh_q[6:0], 1'b1};
            end
         end
      end
   end

   assign sclk      = sclk_q;
   assign mosi      = sh_q[7];
   assign busy      = busy_q;
   assign last_edge = tick && sclk_q && (bit_q == 3'd7);
   assign rx_byte   = rx_q;
endmodule

// File: rtl/snf_addr_pick.sv
module snf_addr_pick #(
   parameter int ADDR_BYTES = 3,
   parameter int AC_W       = 2,
   parameter int IDX_W      = 12
) (
   input  logic [ADDR_BYTES*8-1:0] addr,
   input  logic [AC_W-1:0]         count,
   input  logic [IDX_W-1:0]        idx,
   output logic [7:0]              byte_out
);
   always_comb begin
      byte_out = '0;
      for (int b = 0; b < ADDR_BYTES; b++) begin
         if (int'(count) - 1 - int'(idx) == b)
            byte_out = addr[b*8 +: 8];
      end
   end
endmodule

// File: rtl/snf_phase_next.sv
module snf_phase_next
   import snf_pkg::*;
#(
   parameter int AC_W    = 2,
   parameter int DUMMY_W = 4,
   parameter int CNT_W   = 12
) (
   input  snf_phase_e         cur,
   input  logic [AC_W-1:0]    addr_n,
   input  logic [DUMMY_W-1:0] dummy_n,
   input  logic [CNT_W-1:0]   data_n,
   output snf_phase_e         nxt,
   output logic               more
);
   logic want_addr, want_dummy, want_data;

   assign want_addr  = (cur == PH_OPC) && (addr_n != '0);
   assign want_dummy = ((cur == PH_OPC) || (cur == PH_ADDR)) && (dummy_n != '0);
   assign want_data  = (cur != PH_DATA) && (data_n != '0);

   always_comb begin
      nxt  = PH_DATA;
      more = 1'b1;
      if (want_addr)       nxt = PH_ADDR;
      else if (want_dummy) nxt = PH_DUMMY;
      else if (want_data)  nxt = PH_DATA;
      else                 more = 1'b0;
   end
endmodule

// File: rtl/snf_frame_engine.sv
module snf_frame_engine
   import snf_pkg::*;
#(
   parameter int HALF_DIV   = 2,
   parameter int ADDR_BYTES = 3,
   parameter int DUMMY_W    = 4,
   parameter int CNT_W      = 12,
   parameter int MAX_DATA   = 2112,
   localparam int AC_W      = $clog2(ADDR_BYTES + 1),
   localparam int AW        = ADDR_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [7:0]         cmd_opcode,
   input  logic [AW-1:0]      cmd_addr,
   input  logic [AC_W-1:0]    cmd_addr_cnt,
   input  logic [DUMMY_W-1:0] cmd_dummy_cnt,
   input  logic [CNT_W-1:0]   cmd_data_cnt,
   input  logic               cmd_read,
   input  logic [7:0]         tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic [7:0]         rx_data,
   output logic               rx_valid,
   input  logic               rx_ready,
   output logic               spi_sclk,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic               spi_cs_n,
   output logic               done
);
   generate
      if (ADDR_BYTES < 1) begin : g_bad_addr
         $error("ADDR_BYTES must be at least 1");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (CNT_W < $clog2(MAX_DATA + 1)) begin : g_bad_cnt
         $error("CNT_W too narrow for MAX_DATA");
      end
      if (DUMMY_W > CNT_W) begin : g_bad_dummy
         $error("DUMMY_W must not exceed CNT_W");
      end
   endgenerate

   snf_state_e         state_q;
   snf_phase_e         phase_q;
   logic [CNT_W-1:0]   idx_q;
   logic [7:0]         op_q;
   logic [AW-1:0]      addr_q;
   logic [AC_W-1:0]    an_q;
   logic [DUMMY_W-1:0] dn_q;
   logic [CNT_W-1:0]   data_n_q;
   logic               rd_q;
   logic               cs_n_q;
   logic               done_q;
   logic               rxv_q;
   logic [7:0]         rxd_q;

   logic               go;
   logic [7:0]         out_byte;
   logic [7:0]         addr_byte;
   logic [CNT_W-1:0]   phase_len;
   logic               in_data;
   logic               last_in_phase;
   logic               sh_busy;
   logic               sh_last;
   logic [7:0]         sh_rx;
   snf_phase_e         nxt_phase;
   logic               nxt_more;

   snf_addr_pick #(
      .ADDR_BYTES(ADDR_BYTES), .AC_W(AC_W), .IDX_W(CNT_W)
   ) u_addr (
      .addr(addr_q), .count(an_q), .idx(idx_q), .byte_out(addr_byte)
   );

   snf_phase_next #(
      .AC_W(AC_W), .DUMMY_W(DUMMY_W), .CNT_W(CNT_W)
   ) u_next (
      .cur(phase_q), .addr_n(an_q), .dummy_n(dn_q), .data_n(data_n_q),
      .nxt(nxt_phase), .more(nxt_more)
   );

   snf_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(out_byte), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi), .busy(sh_busy), .last_edge(sh_last),
      .rx_byte(sh_rx)
   );

   assign in_data = (phase_q == PH_DATA);

   always_comb begin
      unique case (phase_q)
         PH_OPC:   phase_len = CNT_W'(1);
         PH_ADDR:  phase_len = CNT_W'(an_q);
         PH_DUMMY: phase_len = CNT_W'(dn_q);
         default:  phase_len = data_n_q;
      endcase
   end

   always_comb begin
      unique case (phase_q)
         PH_OPC:   out_byte = op_q;
         PH_ADDR:  out_byte = addr_byte;
         PH_DUMMY: out_byte = SNF_FILL;
         default:  out_byte = rd_q ? SNF_FILL : tx_data;
      endcase
   end

   assign last_in_phase = (idx_q + CNT_W'(1)) == phase_len;
   assign tx_ready      = (state_q == ST_LAUNCH) && in_data && !rd_q;
   assign go            = (state_q == ST_LAUNCH) && !sh_busy
                          && !(in_data && !rd_q && !tx_valid)
                          && !(in_data && rd_q && rxv_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         phase_q  <= PH_OPC;
         idx_q    <= '0;
         op_q     <= '0;
         addr_q   <= '0;
         an_q     <= '0;
         dn_q     <= '0;
         data_n_q <= '0;
         rd_q     <= 1'b0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  op_q     <= cmd_opcode;
                  addr_q   <= cmd_addr;
                  an_q     <= cmd_addr_cnt;
                  dn_q     <= cmd_dummy_cnt;
                  data_n_q <= cmd_data_cnt;
                  rd_q     <= cmd_read;
                  phase_q  <= PH_OPC;
                  idx_q    <= '0;
                  cs_n_q   <= 1'b0;
                  state_q  <= ST_LAUNCH;
               end
            end
            ST_LAUNCH: begin
               if (go) state_q <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (sh_last) begin
                  if (!last_in_phase) begin
                     idx_q   <= idx_q + CNT_W'(1);
                     state_q <= ST_LAUNCH;
                  end else if (nxt_more) begin
                     phase_q <= nxt_phase;
                     idx_q   <= '0;
                     state_q <= ST_LAUNCH;
                  end else begin
                     state_q <= ST_CLOSE;
                  end
               end
            end
            ST_CLOSE: begin
               cs_n_q  <= 1'b1;
               state_q <= ST_FIN;
            end
            default: begin
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxv_q <= 1'b0;
         rxd_q <= '0;
      end else if (state_q == ST_SHIFT && sh_last && in_data && rd_q) begin
         rxv_q <= 1'b1;
         rxd_q <= sh_rx;
      end else if (rx_ready) begin
         rxv_q <= 1'b0;
      end
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign spi_cs_n  = cs_n_q;
   assign done      = done_q;
   assign rx_valid  = rxv_q;
   assign rx_data   = rxd_q;
endmodule

// File: rtl/snf_frame_checker.sv
module snf_frame_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_ready,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       rx_valid,
   input logic       rx_ready,
   input logic [7:0] rx_data,
   input logic       spi_sclk,
   input logic       spi_cs_n,
   input logic       done
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (spi_cs_n && !spi_sclk));

   a_r6_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sclk |-> !spi_cs_n);

   a_r7_done_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> done);

   a_r7_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> spi_cs_n);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_stall_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ready && !tx_valid) |=> !spi_sclk);

   a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind snf_frame_engine snf_frame_checker u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
   .tx_valid(tx_valid), .tx_ready(tx_ready),
   .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
   .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .done(done)
);

// File: tb/tb_snf_frame_engine.sv
module tb_snf_frame_engine;
   typedef struct packed {
      logic [7:0]  op;
      logic [23:0] addr;
      logic [1:0]  an;
      logic [3:0]  dn;
      logic [11:0] n;
      logic        rd;
      logic [15:0] len;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'h06, 24'h000000, 2'd0, 4'd0, 12'd0, 1'b0, 16'd1},
      '{8'h0F, 24'h0000C0, 2'd1, 4'd0, 12'd1, 1'b1, 16'd3},
      '{8'h13, 24'h001234, 2'd3, 4'd0, 12'd0, 1'b0, 16'd4},
      '{8'h03, 24'h000440, 2'd2, 4'd1, 12'd4, 1'b1, 16'd8},
      '{8'h84, 24'h000123, 2'd2, 4'd0, 12'd5, 1'b0, 16'd8},
      '{8'h9F, 24'h000000, 2'd0, 4'd1, 12'd2, 1'b1, 16'd4},
      '{8'h1F, 24'h0000A0, 2'd1, 4'd0, 12'd1, 1'b0, 16'd3},
      '{8'hAB, 24'h778899, 2'd3, 4'd2, 12'd3, 1'b0, 16'd9}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [7:0]  cmd_opcode = '0;
   logic [23:0] cmd_addr = '0;
   logic [1:0]  cmd_addr_cnt = '0;
   logic [3:0]  cmd_dummy_cnt = '0;
   logic [11:0] cmd_data_cnt = '0;
   logic        cmd_read = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic [7:0]  rx_data;
   logic        rx_valid;
   logic        rx_ready = 1'b1;
   logic        spi_sclk, spi_mosi, spi_miso, spi_cs_n, done;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   snf_frame_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_addr_cnt(cmd_addr_cnt),
      .cmd_dummy_cnt(cmd_dummy_cnt), .cmd_data_cnt(cmd_data_cnt), .cmd_read(cmd_read),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n), .done(done)
   );

   // flash model: captures MOSI on rising SCLK, answers on MISO MSB first
   logic [7:0] mon [0:2199];
   int         mon_n = 0;
   int         bit_n = 0;
   logic [7:0] sh_in = '0;
   logic [7:0] cur_resp;

   function automatic logic [7:0] resp(input int i);
      return 8'(i * 37 + 91);
   endfunction

   assign cur_resp = resp(mon_n);
   assign spi_miso = cur_resp[3'(7 - bit_n)];

   always @(posedge spi_sclk or negedge spi_cs_n) begin
      if (!spi_sclk) begin
         mon_n = 0;
         bit_n = 0;
      end else if (!spi_cs_n) begin
         sh_in = {sh_in[6:0], spi_mosi};
         bit_n = bit_n + 1;
         if (bit_n == 8) begin
            if (mon_n < 2200) mon[mon_n] = sh_in;
            mon_n = mon_n + 1;
            bit_n = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input vec_t v, input int k);
      int a, d;
      a = int'(v.an);
      d = int'(v.dn);
      if (k == 0) return v.op;
      k = k - 1;
      if (k < a) return v.addr[8*(a-1-k) +: 8];
      k = k - a;
      if (k < d) return 8'hFF;
      k = k - d;
      return v.rd ? 8'hFF : 8'(8'h30 + k);
   endfunction

   function automatic string region(input vec_t v, input int k);
      if (k == 0) return "R2";
      if (k <= int'(v.an)) return "R2";
      if (k <= int'(v.an) + int'(v.dn)) return "R3";
      return "R4";
   endfunction

   task automatic run_frame(input vec_t v, input int stall_at, input int stall_len,
                            input int hold_rx, input bit poke, input bit big);
      int tx_idx = 0, rx_n = 0, rx_bad = 0, rx_act = 0, rx_exp = 0;
      int cs_rises = 0, rise_cyc = -1, cyc = 0;
      int stalled = 0, stall_bad = 0, stall_left = -1;
      int held = 0, hold_bad = 0, hold_left = hold_rx, poke_bad = 0;
      int bad_k = -1;
      int base;
      bit took = 0, prev_cs;
      logic [7:0] held_data = '0;
      base = 1 + int'(v.an) + int'(v.dn);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_opcode = v.op; cmd_addr = v.addr; cmd_addr_cnt = v.an;
      cmd_dummy_cnt = v.dn; cmd_data_cnt = v.n; cmd_read = v.rd;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0, "R1", "ready after accept", cmd_ready, 0);
      prev_cs = spi_cs_n;
      while (!done && cyc < 100000) begin
         cyc++;
         if (spi_cs_n && !prev_cs) begin cs_rises++; rise_cyc = cyc; end
         prev_cs = spi_cs_n;
         if (took) tx_idx++;
         if (tx_idx == stall_at && stall_left < 0) stall_left = stall_len;
         if (stall_left > 0) stall_left--;
         tx_valid = (tx_idx < int'(v.n)) && !v.rd && (stall_left <= 0);
         tx_data  = 8'(8'h30 + tx_idx);
         if (tx_ready && !tx_valid) begin
            stalled++;
            if (spi_sclk) stall_bad++;
         end
         took = tx_valid && tx_ready;
         if (rx_valid && rx_n == 0 && hold_left > 0) begin
            rx_ready = 1'b0;
            if (held > 0 && rx_data !== held_data) hold_bad++;
            if (spi_sclk) hold_bad++;
            held_data = rx_data;
            held++;
            hold_left--;
         end else begin
            rx_ready = 1'b1;
         end
         if (rx_valid && rx_ready) begin
            if (rx_data !== resp(base + rx_n) && rx_bad == 0) begin
               rx_act = rx_data; rx_exp = resp(base + rx_n);
            end
            if (rx_data !== resp(base + rx_n)) rx_bad++;
            rx_n++;
         end
         if (poke && cyc == 12) begin
            if (cmd_ready) poke_bad++;
            cmd_opcode = 8'hEE; cmd_addr_cnt = 2'd0; cmd_data_cnt = 12'd0;
            cmd_valid = 1'b1;
         end else begin
            cmd_valid = 1'b0;
         end
         @(negedge clk);
      end
      tx_valid = 1'b0;
      rx_ready = 1'b1;
      check(done === 1'b1, "R7", "done seen before cycle cap", done, 1);
      check(cs_rises == 1, "R6", "chip-select releases per frame", cs_rises, 1);
      check(rise_cyc == cyc, "R7", "cycles from CS release to done", cyc - rise_cyc + 1, 1);
      check(mon_n == int'(v.len), big ? "R10" : "R4", "frame byte count", mon_n, v.len);
      for (int k = 0; k < mon_n && k < int'(v.len) && k < 2200; k++)
         if (bad_k < 0 && mon[k] !== exp_byte(v, k)) bad_k = k;
      if (bad_k >= 0)
         check(1'b0, region(v, bad_k), "MOSI byte", mon[bad_k], exp_byte(v, bad_k));
      else
         check(1'b1, "R2", "MOSI bytes", 0, 0);
      check(rx_n == (v.rd ? int'(v.n) : 0), big ? "R10" : "R4", "rx bytes delivered",
            rx_n, v.rd ? int'(v.n) : 0);
      check(rx_bad == 0, "R5", "rx byte value (MSB first, rising-edge sample)", rx_act, rx_exp);
      if (stall_len > 0) begin
         check(stalled >= 10, "R8", "stall cycles observed", stalled, 10);
         check(stall_bad == 0, "R8", "SCLK high while tx starved", stall_bad, 0);
      end
      if (hold_rx > 0) begin
         check(held == hold_rx, "R9", "rx hold cycles", held, hold_rx);
         check(hold_bad == 0, "R9", "rx data or SCLK moved while unaccepted", hold_bad, 0);
      end
      @(negedge clk);
      check(done == 1'b0, "R7", "done width", done, 0);
      if (poke) begin
         check(poke_bad == 0, "R1", "cmd_ready low mid-frame", poke_bad, 0);
         repeat (6) @(negedge clk);
         check(spi_cs_n == 1'b1 && cmd_ready == 1'b1, "R1",
               "no frame from busy-time request", spi_cs_n, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(spi_cs_n == 1'b1, "R11", "cs_n in reset", spi_cs_n, 1);
      check(spi_sclk == 1'b0, "R11", "sclk in reset", spi_sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", cmd_ready, 1);
      check(done == 1'b0, "R11", "done after reset", done, 0);
      check(tx_ready == 1'b0, "R11", "tx_ready after reset", tx_ready, 0);
      check(rx_valid == 1'b0, "R11", "rx_valid after reset", rx_valid, 0);
      check(spi_sclk == 1'b0, "R5", "sclk idles low", spi_sclk, 0);

      for (int i = 0; i < NV; i++) run_frame(VECS[i], -1, 0, 0, 1'b0, 1'b0);

      // R8: tx stream starves after the first data byte
      run_frame('{8'h84, 24'h000010, 2'd2, 4'd0, 12'd4, 1'b0, 16'd7}, 1, 80, 0, 1'b0, 1'b0);
      // R9: first received byte is left unaccepted for a while
      run_frame('{8'h03, 24'h000000, 2'd2, 4'd1, 12'd3, 1'b1, 16'd7}, -1, 0, 50, 1'b0, 1'b0);
      // R1: request raised while a frame is running
      run_frame('{8'h0F, 24'h0000C0, 2'd1, 4'd0, 12'd1, 1'b1, 16'd3}, -1, 0, 0, 1'b1, 1'b0);
      // R10: full-length read
      run_frame('{8'h03, 24'h000000, 2'd2, 4'd1, 12'd2112, 1'b1, 16'd2116}, -1, 0, 0, 1'b0, 1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule